// File: doc/BRIEF.md
# Slow-Tick Deferred Register Write Controller

This block is the bus-side register front end of a low-rate real-time clock. The CPU writes the clock's timed registers through it: time of day, alarm, interrupt enable mask, prescaler enable and stopwatch. Such a write is not applied at once. It is held in a single staging slot and committed on the next slow tick. With the prescaler on, the raw 32.768 kHz pulse is divided down to one tick per second. With the prescaler off, every raw pulse is a tick. While a write is staged, any further timed write is dropped without notice. Software must therefore poll the write-pending status bit, or wait for write-complete, before it issues the next one.

The commit reaches the separate time-keeping counter block as a one-cycle strobe that carries the register select and the data. The slow tick itself is also exported as a pulse. The block keeps a sticky interrupt status register. Hardware events set its bits whether or not they are enabled. The CPU clears bits by writing ones, and such a clear takes effect on the next clock with no tick wait. The interrupt line is the OR of every status bit whose enable bit is set.

Top module: `slowtick_wr_ctrl`

## Requirements
- R1: A write with select 0 (time), 1 (alarm), 2 (enable mask), 3 (prescaler enable) or 4 (stopwatch) is staged. Nothing is committed until the next slow tick. On the clock after the tick edge, `commit_vld_o` is high for that cycle and `commit_sel_o`/`commit_data_o` carry the staged select and data.
- R2: A timed write that arrives while an earlier one is still pending is discarded. The later commit carries the earlier data.
- R3: Status bit 14 (write pending) reads 1 from the clock after an accepted timed write until the clock after the tick that commits it. Status bit 14 cannot be cleared by software.
- R4: Status bit 15 (write complete) is set together with the commit strobe and stays set until it is cleared.
- R5: A write with select 5 clears every status bit at positions 15 and 6..0 where the data has a 1. The clear is visible on the next clock without any tick, and no write is staged.
- R6: The `evt_i` bits 0..6 (stopwatch, alarm, second, minute, hour, 24-hour, day alarm) set status bits 0..6 whether or not they are enabled. `irq_o` is high exactly when `status_o & enable_o` is nonzero. The enable mask keeps only bits 15 and 6..0 of the committed data.
- R7: While the prescaler enable is 1, `tick_o` pulses on every PRESCALE-th raw pulse. While it is 0, every raw pulse gives a tick and the divider is held at zero. The enable bit is data bit 0 of a select-3 commit.
- R8: If an event sets a status bit in the same cycle that a clear targets it, the bit ends up set. The same holds for write complete and its commit.
- R9: After reset, status, enable mask and staging are clear, no strobe is active, and the prescaler enable is 1.
- R10: Writes with select 6 or 7 are ignored. They stage nothing, set no pending bit and clear no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_tick_i | input | 1 | One-cycle pulse per raw 32.768 kHz period |
| wr_en_i | input | 1 | CPU register write strobe |
| wr_sel_i | input | 3 | Register select of the write |
| wr_data_i | input | DATA_W | Write data |
| evt_i | input | 7 | Hardware event pulses from the counter block |
| tick_o | output | 1 | Slow tick pulse |
| commit_vld_o | output | 1 | One-cycle commit strobe |
| commit_sel_o | output | 3 | Select of the committed write |
| commit_data_o | output | DATA_W | Data of the committed write |
| status_o | output | 16 | Interrupt status (bit 15 complete, 14 pending, 6..0 events) |
| enable_o | output | 16 | Committed interrupt enable mask |
| prescale_en_o | output | 1 | Committed prescaler enable |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The embedded assertions watch every cycle for several properties. A pending write holds and its staged value stays stable until a tick. Every commit strobe coincides with a tick and with write complete. A prescaler that is off turns each raw pulse into a tick. An event always wins over a simultaneous clear. The interrupt line never rises without an enabled status bit.

Some behaviour only the bench's scenarios can show. Those scenarios run a cycle-accurate model through divider sweeps in both prescaler modes, a sweep over all eight selects, and every event bit with and without enables. They show that the discard rule keeps the first value, that the divider count is exact, that clears act without a tick, and that the unused selects have no effect.

// File: rtl/rtcw_pkg.sv
package rtcw_pkg;
  localparam int SEL_W  = 3;
  localparam int EVT_W  = 7;
  localparam int STAT_W = 16;

  localparam logic [SEL_W-1:0] SEL_TIME   = 3'd0;
  localparam logic [SEL_W-1:0] SEL_ALARM  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_IMASK  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_PRESC  = 3'd3;
  localparam logic [SEL_W-1:0] SEL_SWATCH = 3'd4;
  localparam logic [SEL_W-1:0] SEL_ICLR   = 3'd5;

  localparam int BIT_DONE = 15;
  localparam int BIT_PEND = 14;

  // bits of status that are sticky / enableable
  localparam logic [STAT_W-1:0] STICKY_MASK = 16'h807F;

  function automatic logic is_timed(input logic [SEL_W-1:0] sel);
    return (sel <= SEL_SWATCH);
  endfunction
endpackage

// File: rtl/rtcw_prescaler.sv
module rtcw_prescaler #(
  parameter int PRESCALE = 32768
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_tick_i,
  input  logic pen_i,
  output logic tick_now_o,
  output logic tick_o
);
  localparam int CNT_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PRESCALE - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap       = (cnt_q == LAST);
  assign tick_now_o = raw_tick_i & (~pen_i | wrap);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= tick_now_o;
      if (!pen_i)          cnt_q <= '0;
      else if (raw_tick_i) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
  end

  // R7: with prescaler off every raw pulse yields a tick
  a_r7_raw_when_off: assert property (@(posedge clk) disable iff (rst)
    (raw_tick_i && !pen_i) |=> tick_o);
endmodule

// File: rtl/rtcw_stage.sv
module rtcw_stage
  import rtcw_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              tick_i,
  output logic              pend_o,
  output logic              fire_o,
  output logic [SEL_W-1:0]  stg_sel_o,
  output logic [DATA_W-1:0] stg_data_o,
  output logic              commit_vld_o,
  output logic [SEL_W-1:0]  commit_sel_o,
  output logic [DATA_W-1:0] commit_data_o
);
  logic accept;

  assign accept = wr_en_i & is_timed(wr_sel_i) & ~pend_o;
  assign fire_o = tick_i & pend_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o       <= 1'b0;
      commit_vld_o <= 1'b0;
    end else begin
      commit_vld_o <= fire_o;
      if (fire_o) pend_o <= 1'b0;
      if (accept) pend_o <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      stg_sel_o  <= wr_sel_i;
      stg_data_o <= wr_data_i;
    end
    if (fire_o) begin
      commit_sel_o  <= stg_sel_o;
      commit_data_o <= stg_data_o;
    end
  end

  // R3: pending persists until a tick arrives
  a_r3_pend_until_tick: assert property (@(posedge clk) disable iff (rst)
    (pend_o && !tick_i) |=> pend_o);
  // R2: the staged value cannot change while a write is pending
  a_r2_staged_stable: assert property (@(posedge clk) disable iff (rst)
    pend_o |=> ($stable(stg_data_o) && $stable(stg_sel_o)) || !$past(pend_o));
endmodule

// File: rtl/rtcw_status.sv
module rtcw_status
  import rtcw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic              done_set_i,
  input  logic [STAT_W-1:0] clr_i,
  input  logic [STAT_W-1:0] en_next_i,
  output logic              done_o,
  output logic [EVT_W-1:0]  evt_o,
  output logic              irq_o
);
  logic             done_d;
  logic [EVT_W-1:0] evt_d;
  logic [STAT_W-1:0] sticky_d;

  assign done_d   = (done_o & ~clr_i[BIT_DONE]) | done_set_i;
  assign evt_d    = (evt_o & ~clr_i[EVT_W-1:0]) | evt_i;
  assign sticky_d = {done_d, 1'b0, {(STAT_W-EVT_W-2){1'b0}}, evt_d};

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o <= 1'b0;
      evt_o  <= '0;
      irq_o  <= 1'b0;
    end else begin
      done_o <= done_d;
      evt_o  <= evt_d;
      irq_o  <= |(sticky_d & en_next_i & STICKY_MASK);
    end
  end

  // R8: an event is never lost to a simultaneous clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
    (|evt_i) |=> ((evt_o & $past(evt_i)) == $past(evt_i)));
  a_r8_done_wins: assert property (@(posedge clk) disable iff (rst)
    done_set_i |=> done_o);
endmodule

// File: rtl/slowtick_wr_ctrl.sv
module slowtick_wr_ctrl
  import rtcw_pkg::*;
#(
  parameter int PRESCALE = 32768,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              raw_tick_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [6:0]        evt_i,
  output logic              tick_o,
  output logic              commit_vld_o,
  output logic [2:0]        commit_sel_o,
  output logic [DATA_W-1:0] commit_data_o,
  output logic [15:0]       status_o,
  output logic [15:0]       enable_o,
  output logic              prescale_en_o,
  output logic              irq_o
);
  logic              tick_now, fire, pend, done;
  logic [SEL_W-1:0]  stg_sel;
  logic [DATA_W-1:0] stg_data;
  logic [EVT_W-1:0]  evt_st;
  logic [STAT_W-1:0] clr, en_d;

  rtcw_prescaler #(.PRESCALE(PRESCALE)) u_div (
    .clk(clk), .rst(rst), .raw_tick_i(raw_tick_i), .pen_i(prescale_en_o),
    .tick_now_o(tick_now), .tick_o(tick_o));

  rtcw_stage #(.DATA_W(DATA_W)) u_stage (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .tick_i(tick_now), .pend_o(pend), .fire_o(fire),
    .stg_sel_o(stg_sel), .stg_data_o(stg_data), .commit_vld_o(commit_vld_o),
    .commit_sel_o(commit_sel_o), .commit_data_o(commit_data_o));

  assign clr  = (wr_en_i && wr_sel_i == SEL_ICLR) ? wr_data_i[STAT_W-1:0] : '0;
  assign en_d = (fire && stg_sel == SEL_IMASK) ? (stg_data[STAT_W-1:0] & STICKY_MASK)
                                               : enable_o;

  rtcw_status u_stat (
    .clk(clk), .rst(rst), .evt_i(evt_i), .done_set_i(fire), .clr_i(clr),
    .en_next_i(en_d), .done_o(done), .evt_o(evt_st), .irq_o(irq_o));

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_o      <= '0;
      prescale_en_o <= 1'b1;
    end else begin
      enable_o <= en_d;
      if (fire && stg_sel == SEL_PRESC) prescale_en_o <= stg_data[0];
    end
  end

  assign status_o = {done, pend, {(STAT_W-EVT_W-2){1'b0}}, evt_st};

  // R1: a commit strobe only ever accompanies a slow tick
  a_r1_commit_on_tick: assert property (@(posedge clk) disable iff (rst)
    commit_vld_o |-> tick_o);
  // R4: write complete is set whenever a commit is delivered
  a_r4_done_on_commit: assert property (@(posedge clk) disable iff (rst)
    commit_vld_o |-> status_o[BIT_DONE]);
  // R6: interrupt only from an enabled status bit
  a_r6_irq_masked: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> |(status_o & enable_o));
  // R9: state straight after reset
  a_r9_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (enable_o == '0 && prescale_en_o && !status_o[BIT_PEND]));
endmodule

// File: tb/sim_slowtick_wr_ctrl.sv
module sim_slowtick_wr_ctrl;
  localparam int P  = 4;
  localparam int DW = 32;

  logic clk = 1'b0, rst = 1'b1;
  logic raw = 1'b0, wen = 1'b0;
  logic [2:0] sel = '0;
  logic [DW-1:0] data = '0;
  logic [6:0] evt = '0;
  logic tick_o, cv, irq, pen;
  logic [2:0] csel;
  logic [DW-1:0] cdata;
  logic [15:0] st, en;

  int checks = 0, errors = 0;
  bit done_flag = 0;

  // model state
  int m_cnt = 0;
  bit m_pen = 1, m_pend = 0, m_done = 0, m_tick = 0, m_cv = 0, m_irq = 0;
  logic [2:0] m_sel = '0, m_csel = '0;
  logic [DW-1:0] m_data = '0, m_cdata = '0;
  logic [6:0] m_evt = '0;
  logic [15:0] m_en = '0;

  always #5 clk = ~clk;

  slowtick_wr_ctrl #(.PRESCALE(P), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .raw_tick_i(raw), .wr_en_i(wen), .wr_sel_i(sel),
    .wr_data_i(data), .evt_i(evt), .tick_o(tick_o), .commit_vld_o(cv),
    .commit_sel_o(csel), .commit_data_o(cdata), .status_o(st), .enable_o(en),
    .prescale_en_o(pen), .irq_o(irq));

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h t=%0t", tag, got, exp, $time);
    end
  endtask

  // one clock: drive at negedge, model the edge, compare at next negedge
  task automatic cyc(input bit r, input bit w, input logic [2:0] s,
                     input logic [DW-1:0] d, input logic [6:0] e);
    bit ft, fire, acc;
    logic [15:0] clr;
    raw = r; wen = w; sel = s; data = d; evt = e;
    @(negedge clk);
    raw = 0; wen = 0; sel = 0; data = 0; evt = 0;
    ft   = r && (!m_pen || m_cnt == P-1);
    fire = ft && m_pend;
    acc  = w && (s <= 3'd4) && !m_pend;
    clr  = (w && s == 3'd5) ? d[15:0] : 16'h0;
    if (!m_pen) m_cnt = 0; else if (r) m_cnt = (m_cnt == P-1) ? 0 : m_cnt + 1;
    m_tick = ft; m_cv = fire;
    if (fire) begin
      m_csel = m_sel; m_cdata = m_data;
      if (m_sel == 3'd2) m_en = m_data[15:0] & 16'h807F;
      if (m_sel == 3'd3) m_pen = m_data[0];
      m_pend = 0;
    end
    m_done = (m_done && !clr[15]) || fire;
    m_evt  = (m_evt & ~clr[6:0]) | e;
    if (acc) begin m_pend = 1; m_sel = s; m_data = d; end
    m_irq = |({m_done, 8'h0, m_evt} & m_en);
    chk("R7 tick", tick_o, m_tick);
    chk("R1 commit_vld", cv, m_cv);
    if (m_cv) begin
      chk("R1 commit_sel", csel, m_csel);
      chk("R2 commit_data", cdata, m_cdata);
    end
    chk("R3 pending", st[14], m_pend);
    chk("R4 done", st[15], m_done);
    chk("R5/R8 event bits", {st[13:7], st[6:0]}, {7'h0, m_evt});
    chk("R6 enable", en, m_en);
    chk("R6 irq", irq, m_irq);
    chk("R7 prescale_en", pen, m_pen);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask
  task automatic wr(input logic [2:0] s, input logic [DW-1:0] d);
    cyc(0, 1, s, d, 0);
  endtask
  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin cyc(1, 0, 0, 0, 0); idle(1); end
  endtask

  initial begin
    #(200000 * 10);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9: reset state
    chk("R9 status", st, 16'h0);
    chk("R9 enable", en, 16'h0);
    chk("R9 prescale_en", pen, 1'b1);
    chk("R9 irq", irq, 1'b0);
    chk("R9 commit_vld", cv, 1'b0);

    // R7: divider sweep, prescaler on
    pulses(3 * P + 1);

    // R1/R3: stage a time write, commit on the tick
    wr(3'd0, 32'h0001_2345);
    chk("R3 pending after write", st[14], 1'b1);
    chk("R1 no early commit", cv, 1'b0);
    pulses(P);

    // R2: second write while pending is dropped
    wr(3'd1, 32'hAAAA_0001);
    wr(3'd1, 32'h5555_0002);
    pulses(P);
    chk("R2 first value kept", m_cdata, 32'hAAAA_0001);

    // R10: unused selects
    wr(3'd6, 32'hFFFF_FFFF);
    chk("R10 sel6 not pending", st[14], 1'b0);
    wr(3'd7, 32'hFFFF_FFFF);
    chk("R10 sel7 not pending", st[14], 1'b0);
    chk("R10 done untouched", st[15], 1'b1);

    // sweep over every select
    for (int s = 0; s < 8; s++) begin
      logic [DW-1:0] d;
      d = (s == 3) ? 32'h1 : (s == 2) ? 32'h0 : 32'hC0DE_0000 + s;
      wr(3'(s), d);
      pulses(P);
    end

    // R5: immediate clear of write complete, also while pending
    wr(3'd4, 32'h77);
    wr(3'd5, 32'h8000);
    chk("R5 done cleared no tick", st[15], 1'b0);
    chk("R5 still pending", st[14], 1'b1);
    pulses(P);

    // R6: events set regardless of enable, irq only when enabled
    for (int k = 0; k < 7; k++) begin
      cyc(0, 0, 0, 0, 7'(1 << k));
      chk("R6 event set disabled", st[k], 1'b1);
      chk("R6 no irq disabled", irq, 1'b0);
    end
    wr(3'd2, 32'hFFFF_FFFF);
    pulses(P);
    chk("R6 mask kept bits", en, 16'h807F);
    for (int k = 0; k < 7; k++) begin
      wr(3'd5, 32'hFFFF);
      chk("R6 irq off after clear", irq, 1'b0);
      cyc(0, 0, 0, 0, 7'(1 << k));
      chk("R6 irq on enabled event", irq, 1'b1);
    end

    // R8: set and clear in the same cycle
    for (int k = 0; k < 7; k++) begin
      cyc(0, 1, 3'd5, 32'h7F, 7'(1 << k));
      chk("R8 set wins", st[k], 1'b1);
    end
    wr(3'd5, 32'hFFFF);

    // R7: prescaler off, every raw pulse ticks
    wr(3'd3, 32'h0);
    pulses(P);
    chk("R7 prescaler off", pen, 1'b0);
    pulses(5);
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 0);
    // write then back-to-back ticks, second write in commit cycle dropped
    wr(3'd0, 32'h11);
    cyc(1, 1, 3'd0, 32'h22, 0);
    cyc(1, 0, 0, 0, 0);
    wr(3'd3, 32'h1);
    pulses(2);
    chk("R7 prescaler back on", pen, 1'b1);
    pulses(2 * P);
    wr(3'd2, 32'h0);
    pulses(P);

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule